// File: doc/BRIEF.md
# Flash access mode controller

This block turns register accesses from a debug or host port into single commands for a byte-wide flash controller. The host sees four byte registers: a control register, the low and high halves of a 16-bit address register, and a data register. The read-mode and write-mode fields of the control register decide what happens when the host touches the data register. An access can simply latch or return the register. It can also program a byte, erase a page or the whole user area, or fetch a byte from flash. A select bit in the same register sends every operation either to the 64 KB main sector or to a 128-byte scratchpad sector.

The block issues one command at a time on a valid/ready port. `cmd_valid` rises the cycle after the triggering access and stays high, with every command field held stable, until the flash side raises `cmd_ready`. The flash side then signals completion with a one-cycle `done` pulse, carrying `done_data` for reads. The controller accepts `done` in any cycle and has no back-pressure on it. The flash side must pulse `done` only for a command it has accepted. `busy` is high from the cycle after the trigger until the cycle after `done`.

Top module: `flash_mode_ctrl`

## Requirements
- R1: After reset the control, address and data registers read 0x00, `busy` is low and no command is issued.
- R2: `reg_sel` picks a register: 0 control, 1 address bits 7:0, 2 address bits 15:8, 3 data. In the control register, bit 7 selects the scratchpad, bits 6:4 are the write mode and bits 3:0 are the read mode. Every register reads back what was written to it.
- R3: In write mode 0, a data write only updates the data register and issues no command.
- R4: In write mode 1, a data write issues a program command (`cmd_op` 0) carrying the byte and the current address. The address register increments by one in the cycle after `done`.
- R5: In write mode 2, a data write of 0xA5 issues a page erase (`cmd_op` 1) whose address has bits 8:0 cleared (512-byte pages). Any other byte issues nothing. An erase never changes the address register.
- R6: In write mode 2 with the main sector selected, an address of 0x7DFE or 0x7DFF turns the erase into a full user-area erase (`cmd_op` 2, address 0).
- R7: With the scratchpad selected, `cmd_scratch` is 1 and only address bits 6:0 are sent, with the upper bits zero. An erase in this case is always a page erase at address 0 that covers the whole sector, never a full erase.
- R8: In read mode 0, a data read returns the register and issues nothing. In read mode 1, a data read issues a read command (`cmd_op` 3) whenever the block is idle. On `done`, the returned byte is loaded into the data register.
- R9: In read mode 2, a data read issues a read command only if the block is idle and the result of the last completed read has already been read out of the data register.
- R10: Write modes 3 to 7 and read modes 3 to 15 issue no command.
- R11: While `busy` is high, a data access that would start a command is ignored: no command is issued and the data register keeps its value.
- R12: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_op`, `cmd_addr`, `cmd_scratch` and `cmd_data` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select for host access |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (side effects on data register) |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Selected register contents |
| busy | output | 1 | A command is outstanding |
| cmd_valid | output | 1 | Command offered to flash side |
| cmd_ready | input | 1 | Flash side accepts the command |
| cmd_op | output | 2 | 0 program, 1 page erase, 2 full erase, 3 read |
| cmd_scratch | output | 1 | Command targets the scratchpad sector |
| cmd_addr | output | 16 | Command byte or page address |
| cmd_data | output | 8 | Byte to program |
| done | input | 1 | One-cycle completion pulse |
| done_data | input | 8 | Read result, valid with done |

## Verification
A stuck or wrong sequencer state shows up at the ports within a cycle or two. Either `busy` never falls after `done`, or a second command leaves while one is outstanding. A lost read result shows as the next data read returning the old byte. A wrong consumed-result flag in read mode 2 shows up on the very next data read: it either fires an extra read command or withholds one. A bad address path appears on `cmd_addr` at the moment of issue. A missed post-program increment appears on the following read of the address register.

// File: rtl/flash_mode_pkg.sv
package flash_mode_pkg;
  typedef enum logic [1:0] {
    OP_PROG       = 2'd0,
    OP_ERASE_PAGE = 2'd1,
    OP_ERASE_ALL  = 2'd2,
    OP_READ       = 2'd3
  } fop_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_e;

  localparam logic [1:0] SEL_CTRL    = 2'd0;
  localparam logic [1:0] SEL_ADDR_LO = 2'd1;
  localparam logic [1:0] SEL_ADDR_HI = 2'd2;
  localparam logic [1:0] SEL_DATA    = 2'd3;

  localparam logic [2:0] WM_LATCH = 3'd0;
  localparam logic [2:0] WM_PROG  = 3'd1;
  localparam logic [2:0] WM_ERASE = 3'd2;

  localparam logic [3:0] RM_LATCH  = 4'd0;
  localparam logic [3:0] RM_STREAM = 4'd1;
  localparam logic [3:0] RM_ONCE   = 4'd2;
endpackage

// File: rtl/flash_mode_decode.sv
module flash_mode_decode
  import flash_mode_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int PAGE_BITS    = 9,
  parameter int SCRATCH_BITS = 7,
  parameter logic [DATA_W-1:0] ERASE_KEY       = 8'hA5,
  parameter logic [ADDR_W-1:0] FULL_ERASE_ADDR = 16'h7DFE
) (
  input  logic [7:0]        ctrl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              busy,
  input  logic              unread,
  output logic              fire,
  output logic              wr_blocked,
  output fop_e              op,
  output logic [ADDR_W-1:0] op_addr
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~(ADDR_W'((1 << PAGE_BITS) - 1));

  logic       scratch;
  logic [2:0] wmode;
  logic [3:0] rmode;
  logic       wr_starts;
  logic       full_hit;
  logic [ADDR_W-1:0] scr_addr;

  assign scratch  = ctrl[7];
  assign wmode    = ctrl[6:4];
  assign rmode    = ctrl[3:0];
  assign full_hit = (addr[ADDR_W-1:1] == FULL_ERASE_ADDR[ADDR_W-1:1]);
  assign scr_addr = ADDR_W'(addr[SCRATCH_BITS-1:0]);

  // Would this data write launch a command if the sequencer were free?
  always_comb begin
    wr_starts = 1'b0;
    if (data_wr) begin
      if (wmode == WM_PROG) wr_starts = 1'b1;
      else if (wmode == WM_ERASE && wdata == ERASE_KEY) wr_starts = 1'b1;
    end
  end

  assign wr_blocked = wr_starts && busy;

  always_comb begin
    fire = 1'b0;
    op   = OP_READ;
    if (data_wr) begin
      fire = wr_starts && !busy;
      if (wmode == WM_PROG) op = OP_PROG;
      else op = (!scratch && full_hit) ? OP_ERASE_ALL : OP_ERASE_PAGE;
    end else if (data_rd && !busy) begin
      op = OP_READ;
      if (rmode == RM_STREAM) fire = 1'b1;
      else if (rmode == RM_ONCE) fire = !unread;
    end
  end

  always_comb begin
    case (op)
      OP_ERASE_PAGE: op_addr = scratch ? '0 : (addr & PAGE_MASK);
      OP_ERASE_ALL:  op_addr = '0;
      default:       op_addr = scratch ? scr_addr : addr;
    endcase
  end
endmodule

// File: rtl/flash_mode_seq.sv
module flash_mode_seq
  import flash_mode_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  fop_e              op_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              scratch_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              cmd_ready,
  input  logic              done,
  output logic              busy,
  output logic              cmd_valid,
  output fop_e              cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_scratch,
  output logic [DATA_W-1:0] cmd_data,
  output logic              done_prog,
  output logic              done_read
);
  seq_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= SQ_IDLE;
      cmd_op      <= OP_PROG;
      cmd_addr    <= '0;
      cmd_scratch <= 1'b0;
      cmd_data    <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (fire) begin
          state       <= SQ_ISSUE;
          cmd_op      <= op_in;
          cmd_addr    <= addr_in;
          cmd_scratch <= scratch_in;
          cmd_data    <= data_in;
        end
        SQ_ISSUE: if (cmd_ready) state <= SQ_WAIT;
        SQ_WAIT:  if (done) state <= SQ_IDLE;
        default:  state <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (state != SQ_IDLE);
  assign cmd_valid = (state == SQ_ISSUE);
  assign done_prog = (state == SQ_WAIT) && done && (cmd_op == OP_PROG);
  assign done_read = (state == SQ_WAIT) && done && (cmd_op == OP_READ);
endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import flash_mode_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int PAGE_BITS    = 9,
  parameter int SCRATCH_BITS = 7,
  parameter logic [DATA_W-1:0] ERASE_KEY       = 8'hA5,
  parameter logic [ADDR_W-1:0] FULL_ERASE_ADDR = 16'h7DFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              busy,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic              cmd_scratch,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              done,
  input  logic [DATA_W-1:0] done_data
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [7:0]        ctrl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              unread_q;

  logic              data_wr, data_rd;
  logic              fire, wr_blocked;
  fop_e              dec_op;
  logic [ADDR_W-1:0] dec_addr;
  fop_e              seq_op;
  logic              done_prog, done_read;

  assign data_wr = reg_wr && (reg_sel == SEL_DATA);
  assign data_rd = reg_rd && (reg_sel == SEL_DATA);

  flash_mode_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS),
    .SCRATCH_BITS(SCRATCH_BITS), .ERASE_KEY(ERASE_KEY),
    .FULL_ERASE_ADDR(FULL_ERASE_ADDR)
  ) u_dec (
    .ctrl(ctrl_q), .addr(addr_q), .wdata(reg_wdata),
    .data_wr(data_wr), .data_rd(data_rd), .busy(busy), .unread(unread_q),
    .fire(fire), .wr_blocked(wr_blocked), .op(dec_op), .op_addr(dec_addr)
  );

  flash_mode_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .op_in(dec_op), .addr_in(dec_addr),
    .scratch_in(ctrl_q[7]), .data_in(reg_wdata), .cmd_ready(cmd_ready),
    .done(done), .busy(busy), .cmd_valid(cmd_valid), .cmd_op(seq_op),
    .cmd_addr(cmd_addr), .cmd_scratch(cmd_scratch), .cmd_data(cmd_data),
    .done_prog(done_prog), .done_read(done_read)
  );

  assign cmd_op = seq_op;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      unread_q <= 1'b0;
    end else begin
      if (reg_wr && reg_sel == SEL_CTRL) ctrl_q <= reg_wdata;

      if (done_prog) addr_q <= addr_q + 1'b1;
      else if (reg_wr && reg_sel == SEL_ADDR_LO) addr_q[DATA_W-1:0] <= reg_wdata;
      else if (reg_wr && reg_sel == SEL_ADDR_HI) addr_q[ADDR_W-1:DATA_W] <= HI_W'(reg_wdata);

      if (done_read) data_q <= done_data;
      else if (data_wr && !wr_blocked) data_q <= reg_wdata;

      if (done_read) unread_q <= 1'b1;
      else if (data_rd) unread_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL:    reg_rdata = DATA_W'(ctrl_q);
      SEL_ADDR_LO: reg_rdata = addr_q[DATA_W-1:0];
      SEL_ADDR_HI: reg_rdata = DATA_W'(addr_q[ADDR_W-1:DATA_W]);
      default:     reg_rdata = data_q;
    endcase
  end
endmodule

// File: rtl/flash_mode_chk.sv
module flash_mode_chk #(
  parameter int ADDR_W       = 16,
  parameter int PAGE_BITS    = 9,
  parameter int SCRATCH_BITS = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic              cmd_scratch,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              done,
  input logic [ADDR_W-1:0] addr_q
);
  // R12
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_op)
                                && $stable(cmd_scratch));

  // R11
  offer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);

  // R11
  done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cmd_valid && done |=> !busy);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  // R7
  scratch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_scratch |-> (cmd_addr >> SCRATCH_BITS) == '0);

  // R5
  page_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd1 && !cmd_scratch
      |-> cmd_addr[PAGE_BITS-1:0] == '0);

  // R4
  post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cmd_valid && done && cmd_op == 2'd0
      |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));
endmodule

bind flash_mode_ctrl flash_mode_chk #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SCRATCH_BITS(SCRATCH_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_scratch(cmd_scratch),
  .cmd_addr(cmd_addr), .done(done), .addr_q(addr_q)
);

// File: tb/sim_flash_mode_ctrl.sv
module sim_flash_mode_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        busy;
  logic        cmd_valid;
  logic        cmd_ready = 1'b1;
  logic [1:0]  cmd_op;
  logic        cmd_scratch;
  logic [15:0] cmd_addr;
  logic [7:0]  cmd_data;
  logic        done = 1'b0;
  logic [7:0]  done_data = 8'd0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // flash side model
  int          cmd_cnt = 0;
  logic [1:0]  last_op = 2'd0;
  logic [15:0] last_addr = 16'd0;
  logic        last_scr = 1'b0;
  logic [7:0]  last_data = 8'd0;
  int          lat = 3;
  int          dly = 0;
  int          stall = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_scratch(cmd_scratch), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .done(done), .done_data(done_data)
  );

  function automatic logic [7:0] rdval(input logic [15:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  always @(negedge clk) begin
    done = 1'b0;
    if (dly != 0) begin
      dly = dly - 1;
      if (dly == 0) begin
        done = 1'b1;
        done_data = rdval(last_addr);
      end
    end
    if (stall > 0) begin
      cmd_ready = 1'b0;
      stall = stall - 1;
    end else begin
      cmd_ready = 1'b1;
    end
    if (cmd_valid && cmd_ready) begin
      cmd_cnt   = cmd_cnt + 1;
      last_op   = cmd_op;
      last_addr = cmd_addr;
      last_scr  = cmd_scratch;
      last_data = cmd_data;
      dly       = lat;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    #1;
    reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
    @(negedge clk);
    #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] val);
    @(negedge clk);
    #1;
    reg_sel = sel; reg_rd = 1'b1;
    #1;
    val = reg_rdata;
    @(negedge clk);
    #1;
    reg_rd = 1'b0;
  endtask

  task automatic set_addr(input logic [15:0] a);
    wr(2'd1, a[7:0]);
    wr(2'd2, a[15:8]);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 cmd_valid", {31'd0, cmd_valid}, 32'd0);
    rd(2'd0, v); check("R1 ctrl", {24'd0, v}, 32'h00);
    rd(2'd2, v); check("R1 addr hi", {24'd0, v}, 32'h00);
    rd(2'd3, v); check("R1 data", {24'd0, v}, 32'h00);
    check("R1 no command", cmd_cnt, 0);
  endtask

  task automatic t_latch();
    logic [7:0] v;
    int c0;
    wr(2'd0, 8'h8F); rd(2'd0, v); check("R2 ctrl readback", {24'd0, v}, 32'h8F);
    wr(2'd0, 8'h00);
    set_addr(16'h1234);
    c0 = cmd_cnt;
    wr(2'd3, 8'h5A); settle();
    check("R3 no command", cmd_cnt, c0);
    rd(2'd3, v); check("R3 data latched", {24'd0, v}, 32'h5A);
    rd(2'd1, v); check("R2 addr lo", {24'd0, v}, 32'h34);
    rd(2'd2, v); check("R2 addr hi", {24'd0, v}, 32'h12);
  endtask

  task automatic t_prog();
    logic [7:0] v;
    int c0;
    wr(2'd0, 8'h10); set_addr(16'h1234);
    c0 = cmd_cnt;
    wr(2'd3, 8'hC3); settle();
    check("R4 one command", cmd_cnt, c0 + 1);
    check("R4 op", {30'd0, last_op}, 32'd0);
    check("R4 addr", {16'd0, last_addr}, 32'h1234);
    check("R4 data", {24'd0, last_data}, 32'hC3);
    check("R4 main sector", {31'd0, last_scr}, 32'd0);
    rd(2'd1, v); check("R4 addr incremented", {24'd0, v}, 32'h35);
  endtask

  task automatic t_erase();
    logic [7:0] v;
    int c0;
    wr(2'd0, 8'h20); set_addr(16'h1234);
    c0 = cmd_cnt;
    wr(2'd3, 8'h11); settle();
    check("R5 wrong key ignored", cmd_cnt, c0);
    wr(2'd3, 8'hA5); settle();
    check("R5 key erases", cmd_cnt, c0 + 1);
    check("R5 page op", {30'd0, last_op}, 32'd1);
    check("R5 page addr", {16'd0, last_addr}, 32'h1200);
    rd(2'd1, v); check("R5 addr unchanged", {24'd0, v}, 32'h34);
    set_addr(16'h7DFF);
    wr(2'd3, 8'hA5); settle();
    check("R6 full op", {30'd0, last_op}, 32'd2);
    check("R6 full addr", {16'd0, last_addr}, 32'h0000);
    set_addr(16'h7DFE);
    wr(2'd3, 8'hA5); settle();
    check("R6 full op at 7DFE", {30'd0, last_op}, 32'd2);
    set_addr(16'h7DFD);
    wr(2'd3, 8'hA5); settle();
    check("R6 neighbour is page op", {30'd0, last_op}, 32'd1);
    check("R6 neighbour page addr", {16'd0, last_addr}, 32'h7C00);
  endtask

  task automatic t_scratch();
    wr(2'd0, 8'h90); set_addr(16'h00F5);
    wr(2'd3, 8'h42); settle();
    check("R7 scratch flag", {31'd0, last_scr}, 32'd1);
    check("R7 scratch addr", {16'd0, last_addr}, 32'h0075);
    wr(2'd0, 8'hA0); set_addr(16'h7DFE);
    wr(2'd3, 8'hA5); settle();
    check("R7 scratch erase is page", {30'd0, last_op}, 32'd1);
    check("R7 scratch erase addr", {16'd0, last_addr}, 32'h0000);
    check("R7 scratch erase flag", {31'd0, last_scr}, 32'd1);
  endtask

  task automatic t_read_stream();
    logic [7:0] v;
    int c0;
    wr(2'd0, 8'h00); set_addr(16'h0040);
    c0 = cmd_cnt;
    rd(2'd3, v); settle();
    check("R8 mode 0 read quiet", cmd_cnt, c0);
    wr(2'd0, 8'h01);
    rd(2'd3, v); settle();
    check("R8 stream read issued", cmd_cnt, c0 + 1);
    check("R8 read op", {30'd0, last_op}, 32'd3);
    check("R8 read addr", {16'd0, last_addr}, 32'h0040);
    rd(2'd3, v); settle();
    check("R8 result loaded", {24'd0, v}, {24'd0, rdval(16'h0040)});
    check("R8 stream refires", cmd_cnt, c0 + 2);
    wr(2'd0, 8'h00); rd(2'd3, v);
  endtask

  task automatic t_read_once();
    logic [7:0] v;
    int c0;
    wr(2'd0, 8'h02); set_addr(16'h0051);
    c0 = cmd_cnt;
    rd(2'd3, v); settle();
    check("R9 first read issued", cmd_cnt, c0 + 1);
    rd(2'd3, v); settle();
    check("R9 result returned", {24'd0, v}, {24'd0, rdval(16'h0051)});
    check("R9 no extra read", cmd_cnt, c0 + 1);
    rd(2'd3, v); settle();
    check("R9 refires after consume", cmd_cnt, c0 + 2);
    wr(2'd0, 8'h00); rd(2'd3, v);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    int c0;
    c0 = cmd_cnt;
    wr(2'd0, 8'h30); wr(2'd3, 8'hA5); settle();
    wr(2'd0, 8'h70); wr(2'd3, 8'hA5); settle();
    wr(2'd0, 8'h03); rd(2'd3, v); settle();
    wr(2'd0, 8'h0F); rd(2'd3, v); settle();
    check("R10 reserved modes quiet", cmd_cnt, c0);
  endtask

  task automatic t_busy();
    logic [7:0] v;
    int c0;
    lat = 20;
    wr(2'd0, 8'h10); set_addr(16'h0300);
    c0 = cmd_cnt;
    wr(2'd3, 8'h77);
    @(negedge clk);
    check("R11 busy set", {31'd0, busy}, 32'd1);
    wr(2'd3, 8'h88);
    settle();
    check("R11 second write ignored", cmd_cnt, c0 + 1);
    check("R11 first data kept", {24'd0, last_data}, 32'h77);
    rd(2'd3, v); check("R11 data reg unchanged", {24'd0, v}, 32'h77);
    check("R11 busy cleared", {31'd0, busy}, 32'd0);
    lat = 3;
  endtask

  task automatic t_stall();
    logic [15:0] a0;
    int c0;
    wr(2'd0, 8'h10); set_addr(16'h0456);
    c0 = cmd_cnt;
    stall = 8;
    wr(2'd3, 8'h3E);
    @(negedge clk); #2;
    check("R12 offer held", {31'd0, cmd_valid}, 32'd1);
    a0 = cmd_addr;
    @(negedge clk); #2;
    check("R12 still offered", {31'd0, cmd_valid}, 32'd1);
    check("R12 addr stable", {16'd0, cmd_addr}, {16'd0, a0});
    settle();
    check("R12 single handshake", cmd_cnt, c0 + 1);
    check("R12 addr sent", {16'd0, last_addr}, 32'h0456);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_prog();
    t_erase();
    t_scratch();
    t_read_stream();
    t_read_once();
    t_reserved();
    t_busy();
    t_stall();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule